// File: doc/BRIEF.md
# Vector Configuration Decode Tagger

This block sits in the decode stage of a small vector unit whose physical registers are 128 bits wide. It holds the active vector configuration and the granted vector length. It also executes the two forms of the set-length instruction. Every vector instruction that leaves decode carries a frozen copy of the configuration that was in force when it was decoded. Later stages therefore never read a shared configuration register, much as a dynamic rounding mode is taken from a status register and carried with each floating-point instruction.

A set-length instruction with an immediate operand updates the local configuration at decode and does not disturb the pipeline. A set-length instruction whose operand comes from a scalar register applies the value and also raises a serialize request, because decode could not have known that value in advance. Vector operations are checked in two ways. They are checked against the legality of the active configuration. Their register numbers are also checked against the register grouping factor: a group of 2, 4 or 8 registers must start on a register number that is a multiple of the group size.

All outputs come from registers and appear one cycle after the instruction is presented.

Top module: `vcfg_tagger`

## Requirements
- R1: After reset the output valid is low, the configuration is marked illegal with all configuration bits 0, and the vector length is 0.
- R2: A configuration byte is laid out as: bits [2:0] grouping code, bits [5:3] element-width code, bit 6 tail-agnostic, bit 7 mask-agnostic. It is legal only when the grouping code is at most 3 and the element-width code is at most 3.
- R3: A set instruction with a legal configuration grants the smaller of the requested length and the maximum length. The granted length is returned on out_vl, and the tag (out_cfg) holds {0, new configuration byte}.
- R4: The maximum length is 128 × 2^grouping code / (8 × 2^element-width code).
- R5: The register-form set (class 3) takes its configuration from in_cfg_reg and raises out_flush with its result. The immediate form (class 2) takes in_cfg_imm and never raises out_flush.
- R6: A vector operation (class 1) leaves with out_cfg = {illegal bit, active configuration byte} and out_vl = the active length.
- R7: A vector operation traps (out_illegal) when any of vd, vs1 or vs2 is not a multiple of 2^grouping code.
- R8: A vector operation issued while the configuration is illegal traps.
- R9: A set instruction with a reserved encoding makes the configuration illegal, sets the length to 0, and returns 0 on out_vl.
- R10: A non-vector instruction (class 0) never traps or flushes, and it leaves the configuration and length unchanged.
- R11: out_valid follows in_valid exactly one cycle later. The register numbers and class pass through unchanged with it.
- R12: A vector operation presented in the cycle right after a set instruction already carries the new configuration and length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoded instruction present |
| in_class | input | 2 | 0 other, 1 vector op, 2 set immediate, 3 set register |
| in_cfg_imm | input | 8 | Configuration from instruction bits |
| in_cfg_reg | input | 8 | Configuration from scalar register operand |
| in_req_len | input | 16 | Requested vector length |
| in_vd | input | 5 | Destination register number |
| in_vs1 | input | 5 | First source register number |
| in_vs2 | input | 5 | Second source register number |
| out_valid | output | 1 | Tagged instruction present |
| out_class | output | 2 | Class passed through |
| out_vd | output | 5 | Destination passed through |
| out_vs1 | output | 5 | First source passed through |
| out_vs2 | output | 5 | Second source passed through |
| out_cfg | output | 9 | Tag: bit 8 illegal, bits 7:0 configuration |
| out_vl | output | 8 | Granted length (set) or active length |
| out_illegal | output | 1 | Illegal-instruction flag |
| out_flush | output | 1 | Serialize / flush request |

## Verification
Two functions can meet across consecutive cycles. One is a set instruction rewriting the configuration state. The other is a vector operation in the next cycle that must already be tagged with the written value. The bench provokes this by issuing set/use pairs back to back, with no idle cycle between them, across every legal width and grouping combination, and with reserved encodings. The scoreboard model updates its own configuration at the moment the set is pushed, so the expected tag of the following operation reflects the new value. A second overlap is a register-form set that carries a reserved encoding: the bench expects both the flush and the illegal tag in the same result.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;
  localparam int VREG_BITS = 128;
  localparam int MIN_EW    = 8;
  localparam int MAX_MUL   = 8;
  localparam int CFG_W     = 8;
  localparam int REQ_W     = 16;
  localparam int IDX_W     = 5;
  localparam int VL_W      = $clog2(VREG_BITS / MIN_EW * MAX_MUL) + 1;
  localparam int BASE_LEN  = VREG_BITS / MIN_EW;

  typedef enum logic [1:0] {
    CLS_OTHER = 2'd0,
    CLS_VOP   = 2'd1,
    CLS_SETI  = 2'd2,
    CLS_SETR  = 2'd3
  } vclass_e;

  typedef struct packed {
    logic       ma;
    logic       ta;
    logic [2:0] sew;
    logic [2:0] mul;
  } vcfg_t;

  typedef struct packed {
    logic  bad;
    vcfg_t cfg;
  } vtag_t;

  function automatic logic cfg_legal(input vcfg_t c);
    return (c.sew < 3'd4) && (c.mul < 3'd4);
  endfunction

  function automatic logic [VL_W-1:0] vl_max(input vcfg_t c);
    logic [VL_W+3:0] t;
    t = ((VL_W+4)'(BASE_LEN) << c.mul[1:0]) >> c.sew[1:0];
    return t[VL_W-1:0];
  endfunction

  function automatic logic [VL_W-1:0] vl_grant(input logic [REQ_W-1:0] req,
                                               input logic [VL_W-1:0] lim);
    if (req < REQ_W'(lim)) return req[VL_W-1:0];
    return lim;
  endfunction

  function automatic logic idx_aligned(input logic [IDX_W-1:0] idx,
                                       input logic [1:0] mcode);
    logic [IDX_W-1:0] mask;
    mask = (IDX_W'(1) << mcode) - IDX_W'(1);
    return (idx & mask) == '0;
  endfunction
endpackage

// File: rtl/vcfg_state.sv
module vcfg_state
  import vcfg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  vtag_t           wr_tag,
  input  logic [VL_W-1:0] wr_vl,
  output vtag_t           cur_tag,
  output logic [VL_W-1:0] cur_vl
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_tag <= '{bad: 1'b1, cfg: '0};
      cur_vl  <= '0;
    end else if (wr_en) begin
      cur_tag <= wr_tag;
      cur_vl  <= wr_vl;
    end
  end
endmodule

// File: rtl/vcfg_regcheck.sv
module vcfg_regcheck
  import vcfg_pkg::*;
#(
  parameter int N_OPS = 3
) (
  input  logic [N_OPS-1:0][IDX_W-1:0] idx,
  input  logic [1:0]                  mcode,
  output logic                        misaligned
);
  logic [N_OPS-1:0] op_bad;
  for (genvar g = 0; g < N_OPS; g++) begin : g_op
    assign op_bad[g] = !idx_aligned(idx[g], mcode);
  end
  assign misaligned = |op_bad;
endmodule

// File: rtl/vcfg_tagger.sv
module vcfg_tagger
  import vcfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       in_class,
  input  logic [CFG_W-1:0] in_cfg_imm,
  input  logic [CFG_W-1:0] in_cfg_reg,
  input  logic [REQ_W-1:0] in_req_len,
  input  logic [IDX_W-1:0] in_vd,
  input  logic [IDX_W-1:0] in_vs1,
  input  logic [IDX_W-1:0] in_vs2,
  output logic             out_valid,
  output logic [1:0]       out_class,
  output logic [IDX_W-1:0] out_vd,
  output logic [IDX_W-1:0] out_vs1,
  output logic [IDX_W-1:0] out_vs2,
  output logic [CFG_W:0]   out_cfg,
  output logic [VL_W-1:0]  out_vl,
  output logic             out_illegal,
  output logic             out_flush
);
  vtag_t           cur_tag;
  logic [VL_W-1:0] cur_vl;
  vcfg_t           set_cfg;
  logic            set_ok;
  logic [VL_W-1:0] set_vl;
  vtag_t           set_tag;
  logic            misaligned;

  // named internal events
  logic ev_cfg_write;
  logic ev_trap;
  logic ev_flush;

  assign set_cfg = (in_class == CLS_SETR) ? vcfg_t'(in_cfg_reg) : vcfg_t'(in_cfg_imm);
  assign set_ok  = cfg_legal(set_cfg);
  assign set_vl  = set_ok ? vl_grant(in_req_len, vl_max(set_cfg)) : '0;
  assign set_tag = '{bad: !set_ok, cfg: set_cfg};

  assign ev_cfg_write = in_valid && in_class[1];
  assign ev_flush     = in_valid && (in_class == CLS_SETR);
  assign ev_trap      = in_valid && (in_class == CLS_VOP) && (cur_tag.bad || misaligned);

  vcfg_state i_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ev_cfg_write),
    .wr_tag  (set_tag),
    .wr_vl   (set_vl),
    .cur_tag (cur_tag),
    .cur_vl  (cur_vl)
  );

  vcfg_regcheck #(.N_OPS(3)) i_regcheck (
    .idx        ({in_vs2, in_vs1, in_vd}),
    .mcode      (cur_tag.cfg.mul[1:0]),
    .misaligned (misaligned)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_class   <= '0;
      out_vd      <= '0;
      out_vs1     <= '0;
      out_vs2     <= '0;
      out_cfg     <= '0;
      out_vl      <= '0;
      out_illegal <= 1'b0;
      out_flush   <= 1'b0;
    end else begin
      out_valid   <= in_valid;
      out_class   <= in_class;
      out_vd      <= in_vd;
      out_vs1     <= in_vs1;
      out_vs2     <= in_vs2;
      out_cfg     <= ev_cfg_write ? set_tag : cur_tag;
      out_vl      <= ev_cfg_write ? set_vl : cur_vl;
      out_illegal <= ev_trap;
      out_flush   <= ev_flush;
    end
  end
endmodule

// File: rtl/vcfg_tagger_chk.sv
module vcfg_tagger_chk
  import vcfg_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [REQ_W-1:0] in_req_len,
  input logic             out_valid,
  input logic [1:0]       out_class,
  input logic [CFG_W:0]   out_cfg,
  input logic [VL_W-1:0]  out_vl,
  input logic             out_illegal,
  input logic             out_flush,
  input logic             ev_flush
);
  p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_flush_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_flush |-> (out_valid && out_class == 2'd3));
  p_flush_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_flush |=> out_flush);
  p_other_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_class == 2'd0) |-> (!out_illegal && !out_flush));
  p_bad_cfg_trap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_class == 2'd1 && out_cfg[CFG_W]) |-> out_illegal);
  p_grant_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_class[1]) |-> ({{(REQ_W-VL_W){1'b0}}, out_vl} <= $past(in_req_len)));
  p_bad_set_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_class[1] && out_cfg[CFG_W]) |-> (out_vl == '0));
endmodule

bind vcfg_tagger vcfg_tagger_chk i_chk (.*);

// File: tb/test_vcfg_tagger.sv
module test_vcfg_tagger;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [1:0] cls;
    logic [4:0] vd, vs1, vs2;
    logic [8:0] tag;
    logic [7:0] vl;
    logic       ill;
    logic       fl;
    string      req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] in_class = '0;
  logic [7:0] in_cfg_imm = '0, in_cfg_reg = '0;
  logic [15:0] in_req_len = '0;
  logic [4:0] in_vd = '0, in_vs1 = '0, in_vs2 = '0;
  logic out_valid, out_illegal, out_flush;
  logic [1:0] out_class;
  logic [4:0] out_vd, out_vs1, out_vs2;
  logic [8:0] out_cfg;
  logic [7:0] out_vl;

  int checks = 0, errors = 0;
  bit done = 0;
  exp_t sb[$];

  // bench model of the configuration state
  logic [8:0] m_tag = 9'h100;
  int m_vl = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vcfg_tagger i_vcfg_tagger (.*);

  function automatic int b_max(input int e, input int m);
    return (128 * (1 << m)) / (8 * (1 << e));
  endfunction

  task automatic note(input bit ok, input string req, input string what,
                      input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] cls, input logic [7:0] imm, input logic [7:0] rg,
                       input int len, input int vd, input int vs1, input int vs2,
                       input string req);
    exp_t x;
    logic [7:0] c;
    int e, m, gs;
    @(negedge clk);
    in_valid = 1'b1; in_class = cls; in_cfg_imm = imm; in_cfg_reg = rg;
    in_req_len = 16'(len); in_vd = 5'(vd); in_vs1 = 5'(vs1); in_vs2 = 5'(vs2);
    x.cls = cls; x.vd = 5'(vd); x.vs1 = 5'(vs1); x.vs2 = 5'(vs2); x.req = req;
    x.fl = (cls == 2'd3); x.ill = 1'b0;
    if (cls >= 2'd2) begin
      c = (cls == 2'd3) ? rg : imm;
      m = int'(c[2:0]); e = int'(c[5:3]);
      if (e < 4 && m < 4) begin
        m_vl = (len < b_max(e, m)) ? len : b_max(e, m);
        m_tag = {1'b0, c};
      end else begin
        m_vl = 0;
        m_tag = {1'b1, c};
      end
      x.tag = m_tag; x.vl = 8'(m_vl);
    end else begin
      x.tag = m_tag; x.vl = 8'(m_vl);
      if (cls == 2'd1) begin
        gs = 1 << int'(m_tag[1:0]);
        x.ill = m_tag[8] || (vd % gs != 0) || (vs1 % gs != 0) || (vs2 % gs != 0);
      end
    end
    sb.push_back(x);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        if (sb.size() == 0) begin
          note(1'b0, "R11", "unexpected output", 1, 0);
        end else begin
          exp_t x;
          x = sb.pop_front();
          note(out_class == x.cls && out_vd == x.vd && out_vs1 == x.vs1 && out_vs2 == x.vs2,
               "R11", "passthrough", int'({out_class, out_vd, out_vs1, out_vs2}),
               int'({x.cls, x.vd, x.vs1, x.vs2}));
          note(out_cfg == x.tag, x.req, "tag", int'(out_cfg), int'(x.tag));
          note(out_vl == x.vl, x.req, "vl", int'(out_vl), int'(x.vl));
          note(out_illegal == x.ill, x.req, "illegal", int'(out_illegal), int'(x.ill));
          note(out_flush == x.fl, x.req, "flush", int'(out_flush), int'(x.fl));
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    note(out_valid == 1'b0, "R1", "valid after reset", int'(out_valid), 0);
    // R1/R8: vector op right after reset traps with illegal tag and length 0
    drive(2'd1, 8'h00, 8'h00, 0, 0, 0, 0, "R1");
    idle(1);
    // R10: other class under illegal config: no trap
    drive(2'd0, 8'hFF, 8'hFF, 9, 1, 3, 5, "R10");
    // R3/R4: sew8 m1 ta -> max 16
    drive(2'd2, 8'h40, 8'h00, 100, 0, 0, 0, "R3");
    // R12/R6: back-to-back use
    drive(2'd1, 8'h00, 8'h00, 0, 3, 5, 7, "R12");
    // R3: sew64 m8 -> max 16, request 5
    drive(2'd2, 8'h1B, 8'h00, 5, 0, 0, 0, "R3");
    drive(2'd1, 8'h00, 8'h00, 0, 8, 16, 24, "R7");
    drive(2'd1, 8'h00, 8'h00, 0, 8, 9, 0, "R7");
    drive(2'd1, 8'h00, 8'h00, 0, 4, 0, 0, "R7");
    // R5: register form sew8 m8 -> 128, flush
    drive(2'd3, 8'h00, 8'h03, 1000, 0, 0, 0, "R5");
    drive(2'd1, 8'h00, 8'h00, 0, 0, 8, 16, "R6");
    // R2/R9: reserved sew
    drive(2'd2, 8'h28, 8'h00, 7, 0, 0, 0, "R9");
    drive(2'd1, 8'h00, 8'h00, 0, 0, 0, 0, "R8");
    // R2/R9: reserved mul, register form -> flush and illegal together
    drive(2'd3, 8'h00, 8'h04, 7, 0, 0, 0, "R2");
    drive(2'd1, 8'h00, 8'h00, 0, 0, 0, 0, "R2");
    // sew32 m2, request 0
    drive(2'd2, 8'h11, 8'h00, 0, 0, 0, 0, "R3");
    drive(2'd1, 8'h00, 8'h00, 0, 2, 4, 6, "R7");
    drive(2'd1, 8'h00, 8'h00, 0, 2, 1, 6, "R7");
    // R10: other class does not alter the state
    drive(2'd0, 8'h3F, 8'h3F, 77, 0, 0, 0, "R10");
    drive(2'd1, 8'h00, 8'h00, 0, 0, 2, 30, "R10");
    idle(2);
    // R4: sweep all legal combinations, set then use
    for (int e = 0; e < 4; e++) begin
      for (int m = 0; m < 4; m++) begin
        drive(2'd2, 8'((e << 3) | m | 8'h80), 8'h00, 200, 0, 0, 0, "R4");
        drive(2'd1, 8'h00, 8'h00, 0, 1 << m, 0, 0, "R12");
      end
    end
    idle(4);
    note(sb.size() == 0, "R11", "scoreboard drained", sb.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule